// File: doc/BRIEF.md
# MAC Address Table Command Engine

This block keeps a small MAC address table for an Ethernet switch. Software controls it through a bank of 16-bit registers. It writes the address, an entry word (state, trunk flag and port vector), the upper database bits and finally an operation word with the start bit set. The engine then walks every slot of the table once, one slot per clock. It applies the command and clears the busy flag. Results of a search are left in the address and entry registers.

Commands are load (insert or overwrite), purge (a load whose state is zero), ascending get-next within one database, and four sweep variants. Each sweep either covers every database or one database, and either touches all entries or leaves static ones alone. The state value in the entry register picks what a sweep does. A value of zero removes matching entries. A value of all-ones moves entries between ports, taking the source port from the low half of the port vector and the destination from the high half. A destination of all-ones removes the source port instead of relocating it.

Top module: `addr_tbl_engine`

## Requirements
- R1: After reset every register reads 0 and busy is low. Writing register 0 with bit 15 set starts a command. Busy then stays high for exactly DEPTH+1 clock cycles and falls.
- R2: While busy is high, writes to any register are ignored.
- R3: The register addresses are 0 operation, 1 control, 2 entry, and 3, 4 and 5 for the address. The operation word carries start/busy in bit 15, the opcode in bits 14:12 and database bits 3:0 in bits 3:0. The entry word carries the state in bits 3:0, the port vector in bits 11:4 and the trunk flag in bit 15. Address register 3 holds byte 0 in bits 15:8 and byte 1 in bits 7:0; registers 4 and 5 hold bytes 2–3 and 4–5 the same way. The 48-bit key is byte 0 first, most significant.
- R4: Opcode 3 with a nonzero state writes the entry for that address and database, overwriting an existing one.
- R5: Opcode 3 with state 0 removes the entry for that address and database.
- R6: A load of a new key into a table that already holds DEPTH entries leaves the table unchanged.
- R7: Opcode 4 (get-next) returns the entry of that database with the smallest address above the one in the address registers. It puts the address in registers 3–5 and the entry word (state, ports, trunk, other bits 0) in register 2.
- R8: Get-next from the all-ones address starts from the lowest address. When no entry follows, register 2 reads 0 and registers 3–5 read 0xFFFF.
- R9: Opcodes 1 and 2 sweep every database, and opcodes 5 and 6 sweep the given database only. With entry state 0 a sweep removes each matching entry.
- R10: State 0xE marks a static entry. Opcodes 2 and 6 skip static entries, while opcodes 1 and 5 include them.
- R11: A sweep with entry state 0xF is a move. In every matching entry whose port vector has the source port (bits 7:4 of the entry word) set, it clears that bit and sets the destination port (bits 11:8).
- R12: A move whose destination is 0xF only clears the source port, and it removes an entry whose port vector becomes empty.
- R13: The database number is 8 bits: bits 15:12 of the control register above bits 3:0 of the operation word. Entries of other databases are invisible to get-next and to single-database sweeps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| busy | output | 1 | Command in progress |

## Verification
The embedded assertions check the following on every cycle:
- a start write raises busy;
- the last pass of a command drops it;
- a register write during a scan leaves the registers untouched;
- a purge empties the slot it hit;
- an unsuccessful get-next leaves the all-ones address.

Only the bench scenarios can show the parts that depend on the whole table's content. These are the ascending order of get-next, the overwrite-versus-insert choice, dropping a load into a full table, the static-entry exemption, the move and remove port arithmetic, and the isolation between databases.

// File: rtl/addr_tbl_pkg.sv
package addr_tbl_pkg;

   typedef enum logic [2:0] {
      OPC_NONE         = 3'd0,
      OPC_SWEEP_ALL    = 3'd1,
      OPC_SWEEP_DYN    = 3'd2,
      OPC_LOAD         = 3'd3,
      OPC_NEXT         = 3'd4,
      OPC_SWEEP_ALL_DB = 3'd5,
      OPC_SWEEP_DYN_DB = 3'd6,
      OPC_RSVD         = 3'd7
   } opc_e;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_SCAN,
      PH_COMMIT
   } phase_e;

   localparam logic [2:0] RA_OP   = 3'd0;
   localparam logic [2:0] RA_CTRL = 3'd1;
   localparam logic [2:0] RA_DATA = 3'd2;
   localparam logic [2:0] RA_MAC0 = 3'd3;
   localparam logic [2:0] RA_MAC1 = 3'd4;
   localparam logic [2:0] RA_MAC2 = 3'd5;

   localparam logic [3:0] ST_EMPTY  = 4'h0;
   localparam logic [3:0] ST_STATIC = 4'hE;
   localparam logic [3:0] ST_MOVE   = 4'hF;

endpackage

// File: rtl/addr_tbl_dbsel.sv
module addr_tbl_dbsel #(
   parameter int NUM_DB = 256,
   localparam int DBW   = $clog2(NUM_DB)
) (
   input  logic [9:0]     op_low,
   input  logic [3:0]     ctrl_high,
   output logic [DBW-1:0] db
);
   generate
      if (NUM_DB == 16) begin : g_db16
         assign db = op_low[3:0];
      end else if (NUM_DB == 64) begin : g_db64
         assign db = {op_low[9:8], op_low[3:0]};
      end else if (NUM_DB == 256) begin : g_db256
         assign db = {ctrl_high, op_low[3:0]};
      end else begin : g_bad
         $error("addr_tbl_dbsel: NUM_DB must be 16, 64 or 256");
      end
   endgenerate
endmodule

// File: rtl/addr_tbl_sweep.sv
module addr_tbl_sweep
   import addr_tbl_pkg::*;
#(
   parameter int PORTS = 8,
   parameter int DBW   = 8,
   localparam int HW   = PORTS / 2
) (
   input  opc_e             opc,
   input  logic [DBW-1:0]   cmd_db,
   input  logic [3:0]       cmd_state,
   input  logic [PORTS-1:0] cmd_ports,
   input  logic [DBW-1:0]   e_db,
   input  logic [3:0]       e_state,
   input  logic [PORTS-1:0] e_ports,
   output logic [3:0]       n_state,
   output logic [PORTS-1:0] n_ports
);
   logic             is_sweep, all_db, dyn_only, sel;
   logic [HW-1:0]    src, dst;
   logic [PORTS-1:0] vec;

   assign is_sweep = (opc == OPC_SWEEP_ALL) || (opc == OPC_SWEEP_DYN) ||
                     (opc == OPC_SWEEP_ALL_DB) || (opc == OPC_SWEEP_DYN_DB);
   assign all_db   = (opc == OPC_SWEEP_ALL) || (opc == OPC_SWEEP_DYN);
   assign dyn_only = (opc == OPC_SWEEP_DYN) || (opc == OPC_SWEEP_DYN_DB);
   assign sel      = is_sweep && (e_state != ST_EMPTY) &&
                     (all_db || (e_db == cmd_db)) &&
                     !(dyn_only && (e_state == ST_STATIC));
   assign src      = cmd_ports[HW-1:0];
   assign dst      = cmd_ports[PORTS-1:HW];

   always_comb begin
      n_state = e_state;
      n_ports = e_ports;
      vec     = e_ports;
      if (sel) begin
         if (cmd_state == ST_EMPTY) begin
            n_state = ST_EMPTY;
            n_ports = '0;
         end else if (cmd_state == ST_MOVE && 32'(src) < PORTS &&
                      ((e_ports >> src) & PORTS'(1)) != '0) begin
            vec = vec & ~(PORTS'(1) << src);
            if (dst == '1) begin
               if (vec == '0) n_state = ST_EMPTY;
            end else if (32'(dst) < PORTS) begin
               vec = vec | (PORTS'(1) << dst);
            end
            n_ports = vec;
         end
      end
   end
endmodule

// File: rtl/addr_tbl_engine.sv
module addr_tbl_engine
   import addr_tbl_pkg::*;
#(
   parameter int DEPTH  = 64,
   parameter int PORTS  = 8,
   parameter int NUM_DB = 256,
   localparam int IW    = $clog2(DEPTH),
   localparam int DBW   = $clog2(NUM_DB)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [2:0]  wr_addr,
   input  logic [15:0] wr_data,
   input  logic [2:0]  rd_addr,
   output logic [15:0] rd_data,
   output logic        busy
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("addr_tbl_engine: DEPTH must be at least 2");
      end
      if (PORTS < 2 || PORTS > 10 || (PORTS % 2) != 0) begin : g_bad_ports
         $error("addr_tbl_engine: PORTS must be even and between 2 and 10");
      end
   endgenerate

   phase_e          phase;
   logic [14:0]     op_q;
   logic [15:0]     ctrl_q, data_q;
   logic [15:0]     mac_q [3];
   logic [IW-1:0]   idx;

   logic [47:0]     t_mac   [DEPTH];
   logic [DBW-1:0]  t_db    [DEPTH];
   logic [3:0]      t_state [DEPTH];
   logic            t_trunk [DEPTH];
   logic [PORTS-1:0] t_ports [DEPTH];

   logic            hit_v, free_v, best_v;
   logic [IW-1:0]   hit_idx, free_idx, best_idx;
   logic [47:0]     best_mac;

   opc_e            opc;
   logic [DBW-1:0]  cmd_db;
   logic [47:0]     cur_mac;
   logic [3:0]      cmd_state;
   logic [PORTS-1:0] cmd_ports;
   logic [3:0]      n_state;
   logic [PORTS-1:0] n_ports;
   logic            restart, e_live, cand;
   logic [15:0]     best_word;

   assign busy      = (phase != PH_IDLE);
   assign opc       = opc_e'(op_q[14:12]);
   assign cur_mac   = {mac_q[0], mac_q[1], mac_q[2]};
   assign cmd_state = data_q[3:0];
   assign cmd_ports = data_q[4 +: PORTS];
   assign restart   = (cur_mac == '1);
   assign e_live    = (t_state[idx] != ST_EMPTY);
   assign cand      = e_live && (t_db[idx] == cmd_db) &&
                      (restart || t_mac[idx] > cur_mac) &&
                      (!best_v || t_mac[idx] < best_mac);

   addr_tbl_dbsel #(.NUM_DB(NUM_DB)) u_dbsel (
      .op_low    (op_q[9:0]),
      .ctrl_high (ctrl_q[15:12]),
      .db        (cmd_db)
   );

   addr_tbl_sweep #(.PORTS(PORTS), .DBW(DBW)) u_sweep (
      .opc       (opc),
      .cmd_db    (cmd_db),
      .cmd_state (cmd_state),
      .cmd_ports (cmd_ports),
      .e_db      (t_db[idx]),
      .e_state   (t_state[idx]),
      .e_ports   (t_ports[idx]),
      .n_state   (n_state),
      .n_ports   (n_ports)
   );

   always_comb begin
      best_word              = '0;
      best_word[3:0]         = t_state[best_idx];
      best_word[4 +: PORTS]  = t_ports[best_idx];
      best_word[15]          = t_trunk[best_idx];
   end

   always_comb begin
      case (rd_addr)
         RA_OP:   rd_data = {busy, op_q};
         RA_CTRL: rd_data = ctrl_q;
         RA_DATA: rd_data = data_q;
         RA_MAC0: rd_data = mac_q[0];
         RA_MAC1: rd_data = mac_q[1];
         RA_MAC2: rd_data = mac_q[2];
         default: rd_data = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         op_q     <= '0;
         ctrl_q   <= '0;
         data_q   <= '0;
         for (int i = 0; i < 3; i++) mac_q[i] <= '0;
         idx      <= '0;
         hit_v    <= 1'b0;
         free_v   <= 1'b0;
         best_v   <= 1'b0;
         hit_idx  <= '0;
         free_idx <= '0;
         best_idx <= '0;
         best_mac <= '0;
         for (int i = 0; i < DEPTH; i++) t_state[i] <= ST_EMPTY;
      end else begin
         case (phase)
            PH_IDLE: begin
               if (wr_en) begin
                  case (wr_addr)
                     RA_OP: begin
                        op_q <= wr_data[14:0];
                        if (wr_data[15]) begin
                           phase  <= PH_SCAN;
                           idx    <= '0;
                           hit_v  <= 1'b0;
                           free_v <= 1'b0;
                           best_v <= 1'b0;
                        end
                     end
                     RA_CTRL: ctrl_q   <= wr_data;
                     RA_DATA: data_q   <= wr_data;
                     RA_MAC0: mac_q[0] <= wr_data;
                     RA_MAC1: mac_q[1] <= wr_data;
                     RA_MAC2: mac_q[2] <= wr_data;
                     default: ;
                  endcase
               end
            end
            PH_SCAN: begin
               t_state[idx] <= n_state;
               t_ports[idx] <= n_ports;
               if (e_live && t_mac[idx] == cur_mac && t_db[idx] == cmd_db) begin
                  hit_v   <= 1'b1;
                  hit_idx <= idx;
               end
               if (!e_live && !free_v) begin
                  free_v   <= 1'b1;
                  free_idx <= idx;
               end
               if (cand) begin
                  best_v   <= 1'b1;
                  best_idx <= idx;
                  best_mac <= t_mac[idx];
               end
               if (32'(idx) == DEPTH - 1) phase <= PH_COMMIT;
               else                       idx   <= idx + 1'b1;
            end
            default: begin
               phase <= PH_IDLE;
               if (opc == OPC_LOAD) begin
                  if (cmd_state != ST_EMPTY) begin
                     if (hit_v) begin
                        t_state[hit_idx] <= cmd_state;
                        t_trunk[hit_idx] <= data_q[15];
                        t_ports[hit_idx] <= cmd_ports;
                     end else if (free_v) begin
                        t_mac[free_idx]   <= cur_mac;
                        t_db[free_idx]    <= cmd_db;
                        t_state[free_idx] <= cmd_state;
                        t_trunk[free_idx] <= data_q[15];
                        t_ports[free_idx] <= cmd_ports;
                     end
                  end else if (hit_v) begin
                     t_state[hit_idx] <= ST_EMPTY;
                  end
               end else if (opc == OPC_NEXT) begin
                  if (best_v) begin
                     mac_q[0] <= best_mac[47:32];
                     mac_q[1] <= best_mac[31:16];
                     mac_q[2] <= best_mac[15:0];
                     data_q   <= best_word;
                  end else begin
                     for (int i = 0; i < 3; i++) mac_q[i] <= '1;
                     data_q <= '0;
                  end
               end
            end
         endcase
      end
   end

   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && wr_en && wr_addr == RA_OP && wr_data[15]) |=> busy); // R1

   AST_COMMIT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_COMMIT) |=> !busy); // R1

   AST_HOLD_REGS: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SCAN && wr_en) |=> ($stable(data_q) && $stable(ctrl_q) &&
      $stable(op_q) && $stable(mac_q[0]) && $stable(mac_q[1]) && $stable(mac_q[2]))); // R2

   AST_PURGE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_COMMIT && opc == OPC_LOAD && cmd_state == ST_EMPTY && hit_v)
      |=> (t_state[$past(hit_idx)] == ST_EMPTY)); // R5

   AST_NEXT_END_MAC: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && opc == OPC_NEXT && data_q[3:0] == ST_EMPTY)
      |-> (cur_mac == '1)); // R8

endmodule

// File: tb/addr_tbl_engine_bench.sv
module addr_tbl_engine_bench;
   localparam int DEPTH = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        busy;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   addr_tbl_engine u_addr_tbl_engine (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
   );

   // ---------------- behavioural reference model ----------------
   typedef struct {
      logic [47:0] mac;
      int          db;
      logic [3:0]  st;
      logic        tr;
      logic [7:0]  pv;
   } ment_t;

   ment_t       mtab[$];
   logic [15:0] m_ctrl = '0, m_data = '0;
   logic [15:0] m_mac [3] = '{16'h0, 16'h0, 16'h0};
   int          mcnt = 0;

   function automatic void model_exec(input logic [15:0] w);
      int          db, opc, found, bi;
      logic [47:0] cur, bm;
      logic [3:0]  st, src, dst;
      logic [7:0]  pv;
      logic        tr, alldb, dyn;
      db  = {m_ctrl[15:12], w[3:0]};
      opc = int'(w[14:12]);
      cur = {m_mac[0], m_mac[1], m_mac[2]};
      st  = m_data[3:0];
      pv  = m_data[11:4];
      tr  = m_data[15];
      if (opc == 3) begin
         found = -1;
         foreach (mtab[i]) if (mtab[i].mac == cur && mtab[i].db == db) found = i;
         if (st != 0) begin
            if (found >= 0) begin
               mtab[found].st = st; mtab[found].pv = pv; mtab[found].tr = tr;
            end else if (mtab.size() < DEPTH) begin
               mtab.push_back('{mac: cur, db: db, st: st, tr: tr, pv: pv});
            end
         end else if (found >= 0) begin
            mtab.delete(found);
         end
      end else if (opc == 4) begin
         bi = -1; bm = '0;
         foreach (mtab[i])
            if (mtab[i].db == db && (cur == '1 || mtab[i].mac > cur) &&
                (bi < 0 || mtab[i].mac < bm)) begin
               bi = i; bm = mtab[i].mac;
            end
         if (bi >= 0) begin
            m_mac[0] = bm[47:32]; m_mac[1] = bm[31:16]; m_mac[2] = bm[15:0];
            m_data = {mtab[bi].tr, 3'b000, mtab[bi].pv, mtab[bi].st};
         end else begin
            m_mac[0] = '1; m_mac[1] = '1; m_mac[2] = '1;
            m_data = '0;
         end
      end else if (opc == 1 || opc == 2 || opc == 5 || opc == 6) begin
         alldb = (opc == 1 || opc == 2);
         dyn   = (opc == 2 || opc == 6);
         src   = pv[3:0];
         dst   = pv[7:4];
         for (int i = mtab.size() - 1; i >= 0; i--) begin
            if ((alldb || mtab[i].db == db) && !(dyn && mtab[i].st == 4'hE)) begin
               if (st == 0) begin
                  mtab.delete(i);
               end else if (st == 4'hF && src < 8 && mtab[i].pv[src[2:0]]) begin
                  mtab[i].pv[src[2:0]] = 1'b0;
                  if (dst == 4'hF) begin
                     if (mtab[i].pv == 0) mtab.delete(i);
                  end else if (dst < 8) begin
                     mtab[i].pv[dst[2:0]] = 1'b1;
                  end
               end
            end
         end
      end
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         mcnt = 0;
      end else if (mcnt > 0) begin
         mcnt = mcnt - 1;
      end else if (wr_en) begin
         case (wr_addr)
            3'd0: if (wr_data[15]) begin model_exec(wr_data); mcnt = DEPTH + 1; end
            3'd1: m_ctrl = wr_data;
            3'd2: m_data = wr_data;
            3'd3: m_mac[0] = wr_data;
            3'd4: m_mac[1] = wr_data;
            3'd5: m_mac[2] = wr_data;
            default: ;
         endcase
      end
   end

   // busy compared with the model on every clock (R1, R2)
   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (busy !== (mcnt != 0)) begin
            failures++;
            $display("FAIL R1 busy actual=%0b expected=%0b", busy, (mcnt != 0));
         end
      end
   end

   // ---------------- tasks ----------------
   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
      rd_addr = a;
      #1;
      chk(rd_data, exp, tag);
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic chk_regs(input string tag);
      chk_rd(3'd2, m_data, tag);
      chk_rd(3'd3, m_mac[0], tag);
      chk_rd(3'd4, m_mac[1], tag);
      chk_rd(3'd5, m_mac[2], tag);
   endtask

   task automatic set_mac(input logic [47:0] m);
      wr(3'd3, m[47:32]); wr(3'd4, m[31:16]); wr(3'd5, m[15:0]);
   endtask

   task automatic cmd(input logic [2:0] opc, input logic [7:0] db);
      wr(3'd1, {db[7:4], 12'h000});
      wr(3'd0, {1'b1, opc, 8'h00, db[3:0]});
      wait_idle();
   endtask

   task automatic load(input logic [47:0] m, input logic [7:0] db, input logic [15:0] d);
      set_mac(m);
      wr(3'd2, d);
      cmd(3'd3, db);
   endtask

   task automatic walk(input logic [7:0] db, input int exp_n, input string tag);
      int n = 0;
      set_mac('1);
      for (int k = 0; k < DEPTH + 4; k++) begin
         cmd(3'd4, db);
         chk_regs(tag);
         if (m_data[3:0] == 0) break;
         n++;
      end
      chk(16'(n), 16'(exp_n), {tag, " count"});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      for (int a = 0; a < 6; a++) chk_rd(3'(a), 16'h0000, "R1 reset reg");
      chk(16'(busy), 16'h0, "R1 reset busy");

      // R3/R4: loads into database 5 and 0x25
      load(48'h0011_2233_4410, 8'h05, 16'h0037);   // state 7, ports 0,1
      load(48'h0011_2233_4420, 8'h05, 16'h004E);   // static, port 2
      load(48'h0011_2233_4405, 8'h05, 16'h8013);   // trunk, state 3, port 0
      load(48'h0011_2233_4400, 8'h25, 16'h0085);   // other database (R13)
      walk(8'h05, 3, "R7 R8 R3 walk db5");
      walk(8'h25, 1, "R13 walk db25");

      // R4: overwrite existing key
      load(48'h0011_2233_4410, 8'h05, 16'h0066);
      set_mac(48'h0011_2233_440F);
      cmd(3'd4, 8'h05);
      chk_regs("R4 overwrite next");
      walk(8'h05, 3, "R4 walk");

      // R5: purge
      load(48'h0011_2233_4405, 8'h05, 16'h0000);
      walk(8'h05, 2, "R5 purge walk");

      // R2: writes during busy are ignored
      set_mac('1);
      wr(3'd1, 16'h0000);
      wr(3'd0, 16'hC005);
      wr(3'd2, 16'hBEEF);
      wr(3'd3, 16'h1234);
      wr(3'd0, 16'hB005);
      wait_idle();
      chk_regs("R2 ignored while busy");

      // R11: move port 1 -> port 5 in db5 (all entries)
      load(48'h0011_2233_4430, 8'h05, 16'h0027);
      wr(3'd2, 16'h051F);
      cmd(3'd5, 8'h05);
      walk(8'h05, 3, "R11 move walk");

      // R12: remove port 5 (destination all-ones), non-static only
      wr(3'd2, 16'h0F5F);
      cmd(3'd6, 8'h05);
      walk(8'h05, 2, "R12 remove walk");

      // R9/R10: non-static sweep of db5 keeps the static entry
      wr(3'd2, 16'h0000);
      cmd(3'd6, 8'h05);
      walk(8'h05, 1, "R10 static kept");
      walk(8'h25, 1, "R13 other db untouched");
      // R9/R10: non-static sweep across all databases
      wr(3'd2, 16'h0000);
      cmd(3'd2, 8'h00);
      walk(8'h25, 0, "R9 dyn all-db");
      walk(8'h05, 1, "R10 static kept all-db");
      // reserved opcode does nothing
      cmd(3'd7, 8'h05);
      walk(8'h05, 1, "R9 reserved opcode");
      wr(3'd2, 16'h0000);
      cmd(3'd1, 8'h00);
      walk(8'h05, 0, "R9 sweep all");

      // R6: fill the table, then one more key is dropped
      for (int i = 0; i < DEPTH; i++)
         load(48'h0000_0000_0100 + 48'(i * 3), 8'h01, 16'h0017);
      load(48'h0000_0000_0001, 8'h01, 16'h0017);
      walk(8'h01, DEPTH, "R6 full table");
      // R9: single-database sweep including static ones
      wr(3'd2, 16'h0000);
      cmd(3'd5, 8'h01);
      walk(8'h01, 0, "R9 sweep db1");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule